// File: doc/BRIEF.md
# Auto-Ranging Frequency Scan Sequencer

This block runs a sweep of frequency measurements over a bank of selectable clock sources, using a separate gated edge counter that it drives through a small register image: gate length, source index, an enable bit, a run bit, a busy flag and a count result. For every source whose bit is set in the select mask, it looks for the longest gate that does not saturate the counter, because a longer gate gives finer resolution. It begins at the longest gate, and each time the count saturates it shortens the gate by one fixed step and measures again.

When a reading fits, the sequencer turns the count into a frequency with a sequential divider, rounding to the nearest integer. It also works out the precision of that reading, which is two million divided by the gate length. Each result goes out on a valid/ready channel together with the source index and an error flag. A stuck counter ends the whole sweep. A one-cycle done pulse marks the end of every sweep, whether it ran to completion or was cut short.

Top module: `freq_scan_seq`

## Requirements
- R1: The first measurement of every selected source uses the longest gate, DUR_MAX (640). The counter is given gate-minus-one on `cntDuration`.
- R2: If the count reads all ones (saturated), the gate is shortened by DUR_STEP (32) and the same source is measured again.
- R3: A saturated reading at the shortest gate DUR_MIN (32) ends the retries. That source is then reported with `resErr`=1, and `resFreq` and `resPrec` are both 0.
- R4: `resPrec` equals 2,000,000 divided by the gate length that produced the result, with the remainder dropped.
- R5: Each measurement follows a fixed order. First comes one cycle with the whole register image at zero. Then comes one cycle with the gate and source set while enable is low. Then enable and run are raised together for one cycle.
- R6: If busy stays high for TOUT_CYC polling cycles, the sweep aborts. That source is reported with `resErr`=1, no further source is reported, and the done pulse follows.
- R7: Once busy falls, enable is dropped before the count is captured.
- R8: Sources are visited in ascending index order from 0 to NUM_SRC-1. An index whose mask bit is 0 is never measured and never reported.
- R9: `resFreq` equals (count × 1,000,000 + gate/2) / gate, which is the count rate rounded to the nearest integer.
- R10: While `resValid` is high and `resReady` is low, the result fields hold their values.
- R11: `scanDone` goes high for exactly one cycle, after the last result has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanStart | input | 1 | Starts a sweep when the block is idle |
| srcMask | input | NUM_SRC | Selects the sources to sweep (bit i selects source i); held for the whole sweep |
| cntDuration | output | CNT_W | Gate length minus one, sent to the counter |
| cntSource | output | SRC_W | Source index sent to the counter |
| cntEnable | output | 1 | Counter enable |
| cntRun | output | 1 | Counter start, raised for one cycle |
| cntBusy | input | 1 | Counter measurement in progress |
| cntValue | input | CNT_W | Count returned by the counter; all ones means saturated |
| resValid | output | 1 | A result is available |
| resReady | input | 1 | The consumer accepts the result |
| resIndex | output | SRC_W | Source index of the result |
| resFreq | output | FREQ_W | Measured frequency in Hz |
| resPrec | output | PREC_W | Precision of the result in Hz |
| resErr | output | 1 | Saturated at every gate, or counter timeout |
| scanDone | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Two events can land in the same polling cycle: busy falling and the timeout window running out. Busy falling wins, so the reading is taken. The bench sets up this collision by giving one source a busy time of exactly TOUT_CYC-1 cycles. It expects that source to produce a normal, correctly rounded result. In a later sweep, a source whose busy time is one cycle longer must abort the sweep with an error result, and the selected source that follows it must never be reported.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic idxFirst;
    logic idxNext;
    logic durLoad;
    logic durStep;
    logic progOn;
    logic toutClr;
    logic toutInc;
    logic capture;
    logic divFreq;
    logic divPrec;
    logic setErr;
  } ctrlStr_t;

  // status from the datapath back to the control FSM
  typedef struct packed {
    logic idxEnabled;
    logic idxLast;
    logic durFloor;
    logic toutHit;
    logic overflow;
    logic divDone;
  } dpSts_t;

endpackage

// File: rtl/scan_divider.sv
module scan_divider #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 10,
  parameter int QUO_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [QUO_W-1:0] quo
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic              busy;
  logic [STEP_W-1:0] stepR;
  logic [DEN_W-1:0]  remR;
  logic [DEN_W-1:0]  denR;
  logic [NUM_W-1:0]  qR;
  logic [DEN_W:0]    shifted;
  logic [DEN_W:0]    diff;
  logic              ge;

  // one restoring step: shift in the next numerator bit, subtract if it fits
  always_comb begin
    shifted = {remR, qR[NUM_W-1]};
    ge      = shifted >= {1'b0, denR};
    diff    = shifted - {1'b0, denR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      stepR <= '0;
      remR  <= '0;
      denR  <= '1;
      qR    <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      stepR <= STEP_W'(NUM_W);
      remR  <= '0;
      denR  <= den;
      qR    <= num;
    end else if (busy) begin
      remR  <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
      qR    <= {qR[NUM_W-2:0], ge};
      stepR <= stepR - 1'b1;
      if (stepR == STEP_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = qR[QUO_W-1:0];

  AST_DIV_REM: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remR < denR)); // R9

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_SRC  = 128,
  parameter int CNT_W    = 16,
  parameter int DUR_MAX  = 640,
  parameter int DUR_STEP = 32,
  parameter int DUR_MIN  = 32,
  parameter int TOUT_CYC = 1000000,
  parameter int FREQ_W   = 32,
  parameter int PREC_W   = 16,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStr_t           str,
  input  logic [NUM_SRC-1:0] srcMask,
  input  logic [CNT_W-1:0]   cntValue,
  output dpSts_t             sts,
  output logic [CNT_W-1:0]   cntDuration,
  output logic [SRC_W-1:0]   cntSource,
  output logic [SRC_W-1:0]   resIndex,
  output logic [FREQ_W-1:0]  resFreq,
  output logic [PREC_W-1:0]  resPrec,
  output logic               resErr
);
  localparam int DUR_W  = $clog2(DUR_MAX + 1);
  localparam int TOUT_W = $clog2(TOUT_CYC + 1);
  localparam int NUM_W  = CNT_W + 21;
  localparam int SCALE  = 1000000;
  localparam int PREC_N = 2000000;
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [SRC_W-1:0]  idxR;
  logic [DUR_W-1:0]  durR;
  logic [TOUT_W-1:0] toutR;
  logic [CNT_W-1:0]  cntR;
  logic              divIsFreq;
  logic              divStart;
  logic              divDone;
  logic [NUM_W-1:0]  divNum;
  logic [FREQ_W-1:0] divQuo;

  assign divStart = str.divFreq | str.divPrec;
  assign divNum   = str.divFreq
                  ? NUM_W'(cntR) * NUM_W'(SCALE) + NUM_W'(durR >> 1)
                  : NUM_W'(PREC_N);

  scan_divider #(.NUM_W(NUM_W), .DEN_W(DUR_W), .QUO_W(FREQ_W)) uDiv (
    .clk  (clk),
    .rstN (rstN),
    .start(divStart),
    .num  (divNum),
    .den  (durR),
    .done (divDone),
    .quo  (divQuo)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxR      <= '0;
      durR      <= DUR_W'(DUR_MAX);
      toutR     <= '0;
      cntR      <= '0;
      divIsFreq <= 1'b0;
      resFreq   <= '0;
      resPrec   <= '0;
      resErr    <= 1'b0;
    end else begin
      if (str.idxFirst)     idxR <= '0;
      else if (str.idxNext) idxR <= idxR + 1'b1;

      if (str.durLoad)      durR <= DUR_W'(DUR_MAX);
      else if (str.durStep) durR <= durR - DUR_W'(DUR_STEP);

      if (str.toutClr)      toutR <= '0;
      else if (str.toutInc) toutR <= toutR + 1'b1;

      if (str.capture) cntR <= cntValue;
      if (divStart)    divIsFreq <= str.divFreq;

      if (str.durLoad) begin
        resErr <= 1'b0;
      end else if (str.setErr) begin
        resErr  <= 1'b1;
        resFreq <= '0;
        resPrec <= '0;
      end else if (divDone) begin
        if (divIsFreq) resFreq <= divQuo;
        else           resPrec <= PREC_W'(divQuo);
      end
    end
  end

  always_comb begin
    sts.idxEnabled = srcMask[idxR];
    sts.idxLast    = idxR == SRC_W'(NUM_SRC - 1);
    sts.durFloor   = durR < DUR_W'(DUR_MIN + DUR_STEP);
    sts.toutHit    = toutR == TOUT_W'(TOUT_CYC - 1);
    sts.overflow   = cntR == CNT_SAT;
    sts.divDone    = divDone;
  end

  assign cntDuration = str.progOn ? CNT_W'(durR) - CNT_W'(1) : '0;
  assign cntSource   = str.progOn ? idxR : '0;
  assign resIndex    = idxR;

  AST_FIRST_DUR: assert property (@(posedge clk) disable iff (!rstN)
    str.durLoad |=> durR == DUR_W'(DUR_MAX)); // R1
  AST_DUR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    str.durStep |=> durR == $past(durR) - DUR_W'(DUR_STEP)); // R2
  AST_DUR_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    durR >= DUR_W'(DUR_MIN)); // R3

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     scanStart,
  input  logic     cntBusy,
  input  logic     resReady,
  input  dpSts_t   sts,
  output ctrlStr_t str,
  output logic     cntEnable,
  output logic     cntRun,
  output logic     resValid,
  output logic     scanDone
);
  typedef enum logic [3:0] {
    S_IDLE, S_PICK, S_CLR, S_PROG, S_GO, S_POLL, S_DIS,
    S_READ, S_CHK, S_DIVF, S_DIVP, S_OUT, S_DONE
  } state_t;

  state_t state, nextState;
  logic   abortR;

  always_comb begin
    nextState = state;
    str       = '0;
    cntEnable = 1'b0;
    cntRun    = 1'b0;
    resValid  = 1'b0;
    scanDone  = 1'b0;
    case (state)
      S_IDLE: if (scanStart) begin
        str.idxFirst = 1'b1;
        nextState    = S_PICK;
      end
      S_PICK: begin
        if (sts.idxEnabled) begin
          str.durLoad = 1'b1;
          nextState   = S_CLR;
        end else if (sts.idxLast) begin
          nextState = S_DONE;
        end else begin
          str.idxNext = 1'b1;
        end
      end
      S_CLR:  nextState = S_PROG;
      S_PROG: begin
        str.progOn = 1'b1;
        nextState  = S_GO;
      end
      S_GO: begin
        str.progOn  = 1'b1;
        str.toutClr = 1'b1;
        cntEnable   = 1'b1;
        cntRun      = 1'b1;
        nextState   = S_POLL;
      end
      S_POLL: begin
        str.progOn = 1'b1;
        cntEnable  = 1'b1;
        if (!cntBusy) begin
          nextState = S_DIS;
        end else if (sts.toutHit) begin
          str.setErr = 1'b1;
          nextState  = S_OUT;
        end else begin
          str.toutInc = 1'b1;
        end
      end
      S_DIS: begin
        str.progOn = 1'b1;
        nextState  = S_READ;
      end
      S_READ: begin
        str.progOn  = 1'b1;
        str.capture = 1'b1;
        nextState   = S_CHK;
      end
      S_CHK: begin
        if (!sts.overflow) begin
          str.divFreq = 1'b1;
          nextState   = S_DIVF;
        end else if (sts.durFloor) begin
          str.setErr = 1'b1;
          nextState  = S_OUT;
        end else begin
          str.durStep = 1'b1;
          nextState   = S_CLR;
        end
      end
      S_DIVF: if (sts.divDone) begin
        str.divPrec = 1'b1;
        nextState   = S_DIVP;
      end
      S_DIVP: if (sts.divDone) nextState = S_OUT;
      S_OUT: begin
        resValid = 1'b1;
        if (resReady) begin
          if (abortR || sts.idxLast) begin
            nextState = S_DONE;
          end else begin
            str.idxNext = 1'b1;
            nextState   = S_PICK;
          end
        end
      end
      S_DONE: begin
        scanDone  = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      abortR <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && scanStart)
        abortR <= 1'b0;
      else if (state == S_POLL && cntBusy && sts.toutHit)
        abortR <= 1'b1;
    end
  end

  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OUT && abortR && resReady) |=> scanDone); // R6

endmodule

// File: rtl/freq_scan_seq.sv
module freq_scan_seq
  import scan_pkg::*;
#(
  parameter int NUM_SRC  = 128,
  parameter int CNT_W    = 16,
  parameter int DUR_MAX  = 640,
  parameter int DUR_STEP = 32,
  parameter int DUR_MIN  = 32,
  parameter int TOUT_CYC = 1000000,
  parameter int FREQ_W   = 32,
  parameter int PREC_W   = 16,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scanStart,
  input  logic [NUM_SRC-1:0] srcMask,
  output logic [CNT_W-1:0]   cntDuration,
  output logic [SRC_W-1:0]   cntSource,
  output logic               cntEnable,
  output logic               cntRun,
  input  logic               cntBusy,
  input  logic [CNT_W-1:0]   cntValue,
  output logic               resValid,
  input  logic               resReady,
  output logic [SRC_W-1:0]   resIndex,
  output logic [FREQ_W-1:0]  resFreq,
  output logic [PREC_W-1:0]  resPrec,
  output logic               resErr,
  output logic               scanDone
);
  ctrlStr_t ctlStr;
  dpSts_t   dpSts;

  scan_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .scanStart(scanStart),
    .cntBusy  (cntBusy),
    .resReady (resReady),
    .sts      (dpSts),
    .str      (ctlStr),
    .cntEnable(cntEnable),
    .cntRun   (cntRun),
    .resValid (resValid),
    .scanDone (scanDone)
  );

  scan_datapath #(
    .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .DUR_MAX(DUR_MAX), .DUR_STEP(DUR_STEP),
    .DUR_MIN(DUR_MIN), .TOUT_CYC(TOUT_CYC), .FREQ_W(FREQ_W), .PREC_W(PREC_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .str        (ctlStr),
    .srcMask    (srcMask),
    .cntValue   (cntValue),
    .sts        (dpSts),
    .cntDuration(cntDuration),
    .cntSource  (cntSource),
    .resIndex   (resIndex),
    .resFreq    (resFreq),
    .resPrec    (resPrec),
    .resErr     (resErr)
  );

  AST_RUN_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    cntRun |-> cntEnable && !$past(cntEnable)
               && cntDuration == $past(cntDuration)); // R5
  AST_READ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    ctlStr.capture |-> !cntEnable && !cntBusy); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(resIndex)
                              && $stable(resFreq) && $stable(resPrec)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone && !resValid); // R11
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resErr |-> resFreq == '0 && resPrec == '0); // R3

endmodule

// File: tb/sim_freq_scan_seq.sv
`timescale 1ns/1ps
module sim_freq_scan_seq;
  localparam int NS   = 128;
  localparam int TOUT = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          scanStart = 1'b0;
  logic [NS-1:0] srcMask = '0;
  logic [15:0]   cntDuration;
  logic [6:0]    cntSource;
  logic          cntEnable, cntRun, cntBusy;
  logic [15:0]   cntValue;
  logic          resValid, resErr, scanDone;
  logic          resReady = 1'b0;
  logic [6:0]    resIndex;
  logic [31:0]   resFreq;
  logic [15:0]   resPrec;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  freq_scan_seq #(.NUM_SRC(NS), .TOUT_CYC(TOUT)) u0 (
    .clk(clk), .rstN(rstN), .scanStart(scanStart), .srcMask(srcMask),
    .cntDuration(cntDuration), .cntSource(cntSource), .cntEnable(cntEnable),
    .cntRun(cntRun), .cntBusy(cntBusy), .cntValue(cntValue),
    .resValid(resValid), .resReady(resReady), .resIndex(resIndex),
    .resFreq(resFreq), .resPrec(resPrec), .resErr(resErr), .scanDone(scanDone)
  );

  // counter model: count = (s*s+1)*gate + s%7, saturating at all ones
  int stuckSrc = -1;
  int edgeSrc  = -1;
  int busyCnt  = 0;
  int lastSrc  = 0;
  int lastDur  = 640;
  int runCount [NS];

  function automatic longint cntOf(int s, int d);
    longint c = longint'(s * s + 1) * d + s % 7;
    return (c > 65535) ? 65535 : c;
  endfunction

  function automatic int latOf(int s);
    if (s == stuckSrc) return TOUT;
    if (s == edgeSrc)  return TOUT - 1;
    return 4;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  assign cntBusy  = busyCnt != 0;
  assign cntValue = 16'(cntOf(lastSrc, lastDur));

  always @(posedge clk) begin
    if (rstN && cntRun) begin
      check(cntEnable == 1'b1, "R5 enable with run", cntEnable, 1);
      busyCnt <= latOf(int'(cntSource));
      lastSrc <= int'(cntSource);
      lastDur <= int'(cntDuration) + 1;
      runCount[cntSource] <= runCount[cntSource] + 1;
    end else if (busyCnt > 0) begin
      busyCnt <= busyCnt - 1;
    end
  end

  task automatic run_scan(input logic [NS-1:0] m, input int abortAt);
    int ptr = 0;
    int got = 0;
    int cyc = 0;
    bit finished = 0;
    bit stalled = 0;
    logic [6:0] hIdx = '0;
    logic [31:0] hFreq = '0;
    for (int i = 0; i < NS; i++) runCount[i] = 0;
    srcMask = m;
    @(negedge clk) scanStart = 1'b1;
    @(negedge clk) scanStart = 1'b0;
    while (!finished) begin
      @(negedge clk);
      cyc++;
      if (stalled && resValid)
        check(resIndex == hIdx && resFreq == hFreq, "R10 hold", resFreq, hFreq);
      resReady = (cyc % 3) != 1;
      stalled = resValid && !resReady;
      hIdx = resIndex;
      hFreq = resFreq;
      if (resValid && resReady) begin
        int e = ptr;
        while (e < NS && !m[e]) e++;
        check(int'(resIndex) == e, "R8 index order", resIndex, e);
        if (int'(resIndex) == abortAt) begin
          check(resErr == 1'b1, "R6 timeout error", resErr, 1);
        end else begin
          int d = 640;
          int att = 1;
          while (d > 32 && cntOf(e, d) >= 65535) begin d -= 32; att++; end
          check(runCount[e] == att, "R1 R2 attempts", runCount[e], att);
          if (cntOf(e, d) >= 65535) begin
            check(resErr == 1'b1 && resFreq == 0 && resPrec == 0,
                  "R3 all saturated", resFreq, 0);
          end else begin
            longint f = (cntOf(e, d) * 1000000 + d / 2) / d;
            check(resErr == 1'b0, "R3 no error", resErr, 0);
            check(resFreq == 32'(f), "R7 R9 frequency", resFreq, f);
            check(resPrec == 16'(2000000 / d), "R4 precision", resPrec, 2000000 / d);
          end
        end
        ptr = int'(resIndex) + 1;
        got++;
        @(negedge clk);
        if (int'(resIndex) == abortAt || ptr >= NS)
          check(scanDone == 1'b1, "R11 done after last", scanDone, 1);
        if (scanDone) finished = 1;
      end else if (scanDone) begin
        finished = 1;
      end
      if (finished) begin
        int rest = 0;
        for (int i = ptr; i < NS; i++) if (m[i] && abortAt < 0) rest++;
        check(rest == 0, "R11 done only at end", rest, 0);
        if (abortAt >= 0) begin
          int exp = 0;
          for (int i = 0; i <= abortAt; i++) if (m[i]) exp++;
          check(got == exp, "R6 sweep aborted", got, exp);
        end
        @(negedge clk);
        check(scanDone == 1'b0, "R11 single pulse", scanDone, 0);
      end
    end
    resReady = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  initial begin
    logic [NS-1:0] m;
    repeat (4) @(negedge clk);
    check(!resValid && !scanDone && !cntEnable && !cntRun, "reset outputs", resValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    run_scan('1, -1);
    m = '0;
    for (int i = 0; i < NS; i++) m[i] = (i % 9 == 2) || i == 0 || i == NS - 1;
    edgeSrc = 20;
    run_scan(m, -1);
    check(runCount[3] == 0, "R8 masked source not measured", runCount[3], 0);
    edgeSrc = -1;
    stuckSrc = 5;
    m = '0;
    m[3] = 1'b1; m[5] = 1'b1; m[9] = 1'b1;
    run_scan(m, 5);
    check(runCount[9] == 0, "R6 later source skipped", runCount[9], 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule